// File: doc/BRIEF.md
# Interrupt Event Register with Graceful Stop

This block holds the interrupt event and mask state of a network controller and drives three interrupt lines from it: transmit, receive and error. Hardware sources set event bits with single-cycle pulses. Software clears them by writing ones to the event register. Each line is the OR of its group's event bits, gated by the matching mask bits. The line is registered and falls only when every masked bit of its group is clear.

A stop-control register accepts graceful stop requests for the receive and transmit directions. If the direction is idle when the request is written, the stop-complete event is raised at once. If a frame is in flight, the completion is held back until the frame-end pulse of that direction. Frame handling itself happens elsewhere. This block only sees a busy level and a frame-end pulse for each direction.

Software reaches the block through a simple 32-bit register bus with word addressing. Word 0 is the event register, word 1 is the mask register and word 2 is the stop-control register. Reads are combinational.

Top module: `irq_event_ctl`

## Requirements
- R1: After reset the event, mask and stop-control registers read zero, and all three interrupt lines are low.
- R2: A one-cycle pulse on bit b of `evtPulse` sets event bit b. The bit reads set after that clock edge and stays set until software clears it.
- R3: Writing word 0 clears every event bit written as one. Event bits written as zero keep their value.
- R4: If a hardware set and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R5: `irqTx` is high exactly when event bit 20 and mask bit 20 are both set. `irqRx` is high exactly when event bit 7 and mask bit 7 are both set. Both lines change on the same clock edge as the registers they depend on.
- R6: The error group is bits 0-4, 8-11, 16-18, 22-26 and 28-31. `irqErr` is high when any error-group bit is set together with its mask bit. It stays high until every such bit is clear. Bits outside the group (5, 6, 7, 12-15, 19-21, 27) never raise it.
- R7: Word 1 (mask) and word 2 (stop control) read back the last value written. Word 3 reads zero.
- R8: Writing word 2 with bit 4 (receive stop) set while `rxBusy` is low sets event bit 8 on that same clock edge.
- R9: Writing word 2 with bit 4 set while `rxBusy` is high leaves event bit 8 clear until the next `rxFrameEnd` pulse. Bit 8 is set on the edge that samples that pulse.
- R10: Transmit stop works the same way with control bit 3, `txBusy`, `txFrameEnd` and event bit 25, both for the idle case and for the deferred case.
- R11: A write to word 2 with bits 3 and 4 both zero raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busWordAddr | input | WADDR_W | Register word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busWordAddr` (combinational) |
| evtPulse | input | 32 | Per-bit hardware event set pulses |
| rxBusy | input | 1 | A receive frame is in progress |
| rxFrameEnd | input | 1 | Pulse when the receive frame finishes |
| txBusy | input | 1 | A transmit frame is in progress |
| txFrameEnd | input | 1 | Pulse when the transmit frame finishes |
| irqTx | output | 1 | Transmit interrupt |
| irqRx | output | 1 | Receive interrupt |
| irqErr | output | 1 | Error interrupt |

## Verification
The following properties are checked on every cycle:
- set dominance over clear;
- the effect of a write-one clear;
- agreement of the transmit and receive lines with the event and mask state;
- the error line staying low whenever the error group is empty;
- the pending-stop bookkeeping: a deferred stop waits for frame end, and a completion ends the pending state.

Other behaviour can only be shown by the bench's scenarios:
- the exact group membership of all 32 event bits;
- the ordering of a deferred stop completion against the frame-end pulse;
- the error line holding while one masked bit remains.

The bench sweeps every event bit through its set and clear cycle under full and empty masks.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;

  localparam int REG_W = 32;

  // Event bit positions decoded by the interrupt grouping logic
  localparam int BIT_RX_FRAME     = 7;
  localparam int BIT_RX_STOP_DONE = 8;
  localparam int BIT_TX_FRAME     = 20;
  localparam int BIT_TX_STOP_DONE = 25;

  // Stop-control register request bits
  localparam int CTL_RX_STOP = 4;
  localparam int CTL_TX_STOP = 3;

  // Register word selectors
  localparam int SEL_EVT  = 0;
  localparam int SEL_MASK = 1;
  localparam int SEL_CTL  = 2;

  function automatic logic [REG_W-1:0] bitSpan(input int lo, input int hi);
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i >= lo && i <= hi) v[i] = 1'b1;
    end
    return v;
  endfunction

  localparam logic [REG_W-1:0] ERR_GROUP =
      bitSpan(0, 4) | bitSpan(8, 11) | bitSpan(16, 18) | bitSpan(22, 26) | bitSpan(28, 31);
  localparam logic [REG_W-1:0] TX_GROUP = bitSpan(BIT_TX_FRAME, BIT_TX_FRAME);
  localparam logic [REG_W-1:0] RX_GROUP = bitSpan(BIT_RX_FRAME, BIT_RX_FRAME);

  typedef struct packed {
    logic wrEvt;
    logic wrMask;
    logic wrCtl;
    logic doneRx;
    logic doneTx;
  } ctlStrobe_t;

endpackage

// File: rtl/irq_stop_unit.sv
module irq_stop_unit (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  input  logic busy,
  input  logic frameEnd,
  output logic done
);

  logic pendingQ;
  logic pendingD;

  // Completion: immediate when idle (or the frame ends this cycle), else deferred
  assign done = (req && (!busy || frameEnd)) || (pendingQ && frameEnd);

  always_comb begin
    pendingD = pendingQ;
    if (done)     pendingD = 1'b0;
    else if (req) pendingD = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingQ <= 1'b0;
    else       pendingQ <= pendingD;
  end

  // R9 / R10: a pending stop keeps waiting while no frame end arrives
  a_r9_pending_waits: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !frameEnd) |-> !done);

  // R9 / R10: a completion leaves nothing pending
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !pendingQ);

  // R8 / R10: a request on an idle direction never becomes pending
  a_r8_idle_no_pending: assert property (@(posedge clk) disable iff (!rstN)
    (req && !busy && !pendingQ) |=> !pendingQ);

endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_event_pkg::*;
#(
  parameter int WADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [WADDR_W-1:0] busWordAddr,
  input  logic [1:0]         stopBits,     // [0] receive, [1] transmit
  input  logic               rxBusy,
  input  logic               rxFrameEnd,
  input  logic               txBusy,
  input  logic               txFrameEnd,
  output ctlStrobe_t         strb
);

  localparam int NUM_DIR = 2;

  logic wrCtl;
  logic [NUM_DIR-1:0] reqV, busyV, endV, doneV;

  assign wrCtl = busWrEn && (busWordAddr == WADDR_W'(SEL_CTL));
  assign busyV = {txBusy, rxBusy};
  assign endV  = {txFrameEnd, rxFrameEnd};

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    assign reqV[g] = wrCtl && stopBits[g];
    irq_stop_unit u_unit (
      .clk      (clk),
      .rstN     (rstN),
      .req      (reqV[g]),
      .busy     (busyV[g]),
      .frameEnd (endV[g]),
      .done     (doneV[g])
    );
  end

  always_comb begin
    strb.wrEvt  = busWrEn && (busWordAddr == WADDR_W'(SEL_EVT));
    strb.wrMask = busWrEn && (busWordAddr == WADDR_W'(SEL_MASK));
    strb.wrCtl  = wrCtl;
    strb.doneRx = doneV[0];
    strb.doneTx = doneV[1];
  end

endmodule

// File: rtl/irq_event_dp.sv
module irq_event_dp
  import irq_event_pkg::*;
#(
  parameter int WADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [WADDR_W-1:0] busWordAddr,
  input  logic [REG_W-1:0]   busWrData,
  input  logic [REG_W-1:0]   evtPulse,
  output logic [REG_W-1:0]   busRdData,
  output logic               irqTx,
  output logic               irqRx,
  output logic               irqErr
);

  logic [REG_W-1:0] evtQ, maskQ, ctlQ;
  logic [REG_W-1:0] evtD, maskD, ctlD;
  logic [REG_W-1:0] setVec, clrVec;

  always_comb begin
    setVec = evtPulse;
    setVec[BIT_RX_STOP_DONE] = setVec[BIT_RX_STOP_DONE] | strb.doneRx;
    setVec[BIT_TX_STOP_DONE] = setVec[BIT_TX_STOP_DONE] | strb.doneTx;
    clrVec = strb.wrEvt ? busWrData : '0;
    evtD   = (evtQ & ~clrVec) | setVec;     // set dominates clear
    maskD  = strb.wrMask ? busWrData : maskQ;
    ctlD   = strb.wrCtl  ? busWrData : ctlQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ   <= '0;
      maskQ  <= '0;
      ctlQ   <= '0;
      irqTx  <= 1'b0;
      irqRx  <= 1'b0;
      irqErr <= 1'b0;
    end else begin
      evtQ   <= evtD;
      maskQ  <= maskD;
      ctlQ   <= ctlD;
      irqTx  <= |(evtD & maskD & TX_GROUP);
      irqRx  <= |(evtD & maskD & RX_GROUP);
      irqErr <= |(evtD & maskD & ERR_GROUP);
    end
  end

  always_comb begin
    case (busWordAddr)
      WADDR_W'(SEL_EVT):  busRdData = evtQ;
      WADDR_W'(SEL_MASK): busRdData = maskQ;
      WADDR_W'(SEL_CTL):  busRdData = ctlQ;
      default:            busRdData = '0;
    endcase
  end

  // R4: any bit set by hardware reads set after the edge, whatever was written
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((evtQ & $past(setVec)) == $past(setVec)));

  // R3: a write-one clear with no competing set empties those bits
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEvt && ((setVec & busWrData) == '0)) |=> ((evtQ & $past(busWrData)) == '0));

  // R5: transmit and receive lines agree with event and mask state
  a_r5_tx_line: assert property (@(posedge clk) disable iff (!rstN)
    irqTx == (evtQ[BIT_TX_FRAME] && maskQ[BIT_TX_FRAME]));
  a_r5_rx_line: assert property (@(posedge clk) disable iff (!rstN)
    irqRx == (evtQ[BIT_RX_FRAME] && maskQ[BIT_RX_FRAME]));

  // R6: error line is low whenever the error group is empty
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((evtQ & ERR_GROUP) == '0) |-> !irqErr);

endmodule

// File: rtl/irq_event_ctl.sv
module irq_event_ctl
  import irq_event_pkg::*;
#(
  parameter int WADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [WADDR_W-1:0] busWordAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [31:0]        evtPulse,
  input  logic               rxBusy,
  input  logic               rxFrameEnd,
  input  logic               txBusy,
  input  logic               txFrameEnd,
  output logic               irqTx,
  output logic               irqRx,
  output logic               irqErr
);

  ctlStrobe_t strb;

  irq_event_ctrl #(.WADDR_W(WADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busWrEn     (busWrEn),
    .busWordAddr (busWordAddr),
    .stopBits    ({busWrData[CTL_TX_STOP], busWrData[CTL_RX_STOP]}),
    .rxBusy      (rxBusy),
    .rxFrameEnd  (rxFrameEnd),
    .txBusy      (txBusy),
    .txFrameEnd  (txFrameEnd),
    .strb        (strb)
  );

  irq_event_dp #(.WADDR_W(WADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busWordAddr (busWordAddr),
    .busWrData   (busWrData),
    .evtPulse    (evtPulse),
    .busRdData   (busRdData),
    .irqTx       (irqTx),
    .irqRx       (irqRx),
    .irqErr      (irqErr)
  );

endmodule

// File: tb/irq_event_ctl_bench.sv
`timescale 1ns/1ps
module irq_event_ctl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busWordAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] evtPulse = '0;
  logic        rxBusy = 1'b0, rxFrameEnd = 1'b0, txBusy = 1'b0, txFrameEnd = 1'b0;
  logic        irqTx, irqRx, irqErr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  irq_event_ctl u_irq_event_ctl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWordAddr(busWordAddr),
    .busWrData(busWrData), .busRdData(busRdData), .evtPulse(evtPulse),
    .rxBusy(rxBusy), .rxFrameEnd(rxFrameEnd), .txBusy(txBusy), .txFrameEnd(txFrameEnd),
    .irqTx(irqTx), .irqRx(irqRx), .irqErr(irqErr)
  );

  function automatic bit isErr(input int b);
    return (b <= 4) || (b >= 8 && b <= 11) || (b >= 16 && b <= 18) ||
           (b >= 22 && b <= 26) || (b >= 28);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busWordAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busWordAddr = a;
    #0.5;
    d = busRdData;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    evtPulse = v;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic checkLines(input string tag, input bit t, input bit r, input bit e);
    check({tag, " irqTx"}, {31'd0, irqTx}, {31'd0, t});
    check({tag, " irqRx"}, {31'd0, irqRx}, {31'd0, r});
    check({tag, " irqErr"}, {31'd0, irqErr}, {31'd0, e});
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 event", v, 32'h0);
    rd(2'd1, v); check("R1 mask", v, 32'h0);
    rd(2'd2, v); check("R1 ctl", v, 32'h0);
    checkLines("R1", 0, 0, 0);

    // R7 mask readback, unused word
    wr(2'd1, 32'hA5C3_0F96); rd(2'd1, v); check("R7 mask", v, 32'hA5C3_0F96);
    rd(2'd3, v); check("R7 word3", v, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R7 mask all", v, 32'hFFFF_FFFF);

    // R2/R3/R5/R6 sweep over every event bit
    for (int b = 0; b < 32; b++) begin
      pulse(32'd1 << b);
      rd(2'd0, v); check($sformatf("R2 set bit %0d", b), v, 32'd1 << b);
      checkLines($sformatf("R5/R6 bit %0d", b), b == 20, b == 7, isErr(b));
      wr(2'd0, ~(32'd1 << b));
      rd(2'd0, v); check($sformatf("R3 zero-write bit %0d", b), v, 32'd1 << b);
      wr(2'd0, 32'd1 << b);
      rd(2'd0, v); check($sformatf("R3 clear bit %0d", b), v, 32'h0);
      checkLines($sformatf("R3 lines bit %0d", b), 0, 0, 0);
    end

    // R6 masked off: all bits set, mask zero
    wr(2'd1, 32'h0);
    pulse(32'hFFFF_FFFF);
    checkLines("R6 masked", 0, 0, 0);
    wr(2'd1, 32'd1 << 8);
    checkLines("R6 single mask", 0, 0, 1);
    wr(2'd0, 32'hFFFF_FFFF);
    checkLines("R6 emptied", 0, 0, 0);

    // R6 line holds until last masked error bit clears
    wr(2'd1, 32'hFFFF_FFFF);
    pulse((32'd1 << 0) | (32'd1 << 30));
    wr(2'd0, 32'd1);
    checkLines("R6 one left", 0, 0, 1);
    wr(2'd0, 32'd1 << 30);
    checkLines("R6 none left", 0, 0, 0);

    // R4 set and clear same cycle
    @(negedge clk);
    evtPulse = 32'd1 << 20; busWrEn = 1'b1; busWordAddr = 2'd0; busWrData = 32'd1 << 20;
    @(negedge clk);
    evtPulse = '0; busWrEn = 1'b0; busWrData = '0;
    rd(2'd0, v); check("R4 set wins", v, 32'd1 << 20);
    checkLines("R4", 1, 0, 0);
    wr(2'd0, 32'hFFFF_FFFF);

    // R11 control write with no stop bits
    wr(2'd2, 32'hFFFF_FFE7);
    rd(2'd0, v); check("R11 no event", v, 32'h0);
    rd(2'd2, v); check("R7 ctl readback", v, 32'hFFFF_FFE7);

    // R8 receive stop while idle
    wr(2'd2, 32'd1 << 4);
    rd(2'd0, v); check("R8 rx stop idle", v, 32'd1 << 8);
    checkLines("R8", 0, 0, 1);
    wr(2'd0, 32'hFFFF_FFFF);

    // R9 receive stop deferred
    rxBusy = 1'b1;
    wr(2'd2, 32'd1 << 4);
    rd(2'd0, v); check("R9 deferred", v, 32'h0);
    repeat (5) @(negedge clk);
    rd(2'd0, v); check("R9 still waiting", v, 32'h0);
    checkLines("R9 waiting", 0, 0, 0);
    @(negedge clk); rxFrameEnd = 1'b1;
    @(negedge clk); rxFrameEnd = 1'b0; rxBusy = 1'b0;
    rd(2'd0, v); check("R9 done at frame end", v, 32'd1 << 8);
    wr(2'd0, 32'hFFFF_FFFF);

    // R10 transmit stop idle, then deferred, with mask bit 25 off
    wr(2'd2, 32'd1 << 3);
    rd(2'd0, v); check("R10 tx stop idle", v, 32'd1 << 25);
    checkLines("R10 idle", 0, 0, 1);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, ~(32'd1 << 25));
    txBusy = 1'b1;
    wr(2'd2, 32'd1 << 3);
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R10 deferred", v, 32'h0);
    @(negedge clk); txFrameEnd = 1'b1;
    @(negedge clk); txFrameEnd = 1'b0; txBusy = 1'b0;
    rd(2'd0, v); check("R10 done at frame end", v, 32'd1 << 25);
    checkLines("R10 masked off", 0, 0, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule